// File: doc/BRIEF.md
# Buck Converter Fault Protection Manager

This block watches one synchronous buck stage through digitized sense values and decides when the gate drivers must be overridden. Once per switching cycle a strobe delivers the switch-node voltage sampled while the low-side switch conducts. That sample is compared against a programmed current threshold. A second level at one and a half times that threshold trips at once. Otherwise the trip needs four over-threshold samples in a row. The output-sense voltage is compared continuously against fixed millivolt limits. These limits cover under-voltage, over-voltage and a power-good window.

The over-current and under-voltage faults latch both switches off. The over-voltage fault also latches, but it keeps the low-side switch working as a discharge path. It releases that switch below 400 mV and turns it on again above 400 mV. Power-good rises once soft-start is done and the output sits inside the window. It follows the window from then on, and it stays low while any fault is latched. Every latched fault clears only on the power-on reset. All codes are unsigned millivolt values.

The supervisor machine has four states: SUP_SOFTSTART, SUP_GOOD, SUP_OUTSIDE and SUP_SHUTDOWN. It moves from SUP_SOFTSTART to SUP_GOOD or SUP_OUTSIDE when soft-start is done, depending on the window. SUP_GOOD and SUP_OUTSIDE swap whenever the output crosses a window limit. Any of the first three states goes to SUP_SHUTDOWN on an over-current or under-voltage trip, and SUP_SHUTDOWN is left only by reset. The over-voltage machine has three states: OVS_IDLE, OVS_SINK and OVS_RELEASED. OVS_IDLE goes to OVS_SINK above 1000 mV. OVS_SINK goes to OVS_RELEASED below 400 mV, and OVS_RELEASED returns to OVS_SINK above 400 mV. The current detector has two states: OCS_WATCH and OCS_TRIPPED. It moves from OCS_WATCH to OCS_TRIPPED on a trip.

Top module: `buck_fault_mgr`

## Requirements
- R1: On a strobe, a sample strictly above the threshold is a first-level event. A fault_oc trip follows the fourth event in four consecutive strobes. A strobe without an event clears the run. Cycles without a strobe leave the run unchanged.
- R2: On a strobe, a sample strictly above thr + (thr >> 1), computed one bit wider so it cannot wrap, sets fault_oc from that single sample.
- R3: After reset, all outputs are 0. fault_oc and fault_uv, once set, stay set until reset and assert force_all_off, unless R9 applies.
- R4: While ss_done = 1, a sense value below 600 sets fault_uv. While ss_done = 0 the under-voltage check has no effect.
- R5: A sense value above 1000 sets fault_ov. It holds until reset and asserts force_ls_on in the next cycle.
- R6: While fault_ov is set, a sense value below 400 drops force_ls_on and asserts force_all_off. A value above 400 asserts force_ls_on again. A value of exactly 400 keeps the current drive.
- R7: pgood is 0 until ss_done = 1. After that it is 1 exactly while the sense value is within 710..890 inclusive. A window exit by itself asserts neither override output.
- R8: pgood is 0 whenever any fault flag is set. Otherwise it returns to 1 when the sense value re-enters the window.
- R9: force_ls_on takes precedence over force_all_off, and the two are never 1 together.
- R10: Over-current and over-voltage detection work while ss_done = 0.
- R11: Every output reflects the inputs sampled at the previous rising clock edge: one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears all latches |
| cyc_strobe | input | 1 | One-cycle pulse per switching cycle, qualifies ls_sample |
| ls_sample | input | 10 | Switch-node voltage code in mV, taken during low-side conduction |
| oc_thresh | input | 10 | Programmed first-level current threshold code in mV |
| vout_sense | input | 10 | Output-sense voltage code in mV |
| ss_done | input | 1 | Soft-start finished flag |
| force_all_off | output | 1 | Both switches forced off |
| force_ls_on | output | 1 | High-side forced off and low-side forced on |
| fault_oc | output | 1 | Latched over-current fault |
| fault_uv | output | 1 | Latched under-voltage fault |
| fault_ov | output | 1 | Latched over-voltage fault |
| pgood | output | 1 | Output voltage within the power-good window |

## Verification
Every result of this block is due one clock after the cycle whose inputs cause it. That holds for a trip, a window change and a hysteresis flip. The bench therefore drives a full set of inputs on the falling edge. It advances its own model of the expected outputs at the same moment. After one rising edge, it compares all six outputs on the following falling edge. Directed runs place values exactly on each limit and one code past it, at 150/151 for the second level, 400, 710, 890 and 1000. They also hold a run of events across strobe-free cycles and use a threshold whose 1.5 multiple would wrap in ten bits.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    typedef enum logic [1:0] {
        SUP_SOFTSTART,
        SUP_GOOD,
        SUP_OUTSIDE,
        SUP_SHUTDOWN
    } sup_state_t;

    typedef enum logic [1:0] {
        OVS_IDLE,
        OVS_SINK,
        OVS_RELEASED
    } ov_state_t;

    typedef enum logic {
        OCS_WATCH,
        OCS_TRIPPED
    } oc_state_t;

endpackage

// File: rtl/bfm_oc_detect.sv
module bfm_oc_detect
    import bfm_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int OC_RUN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CODE_W-1:0] sample,
    input  logic [CODE_W-1:0] thr,
    output logic              trip,
    output logic              latched
);
    localparam int CNT_W = $clog2(OC_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(OC_RUN - 1);

    oc_state_t        state_q, state_n;
    logic [CNT_W-1:0] run_q, run_n;
    logic [CODE_W:0]  thr_high;
    logic             above_lvl1, above_lvl2;

    // second level = 1.5 x threshold, one bit wider so it never wraps
    assign thr_high   = {1'b0, thr} + {2'b00, thr[CODE_W-1:1]};
    assign above_lvl1 = sample > thr;
    assign above_lvl2 = {1'b0, sample} > thr_high;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCS_WATCH;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
        end
    end

    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        trip    = 1'b0;
        unique case (state_q)
            OCS_WATCH: begin
                if (strobe) begin
                    if (above_lvl2 || (above_lvl1 && run_q == RUN_LAST)) begin
                        trip    = 1'b1;
                        state_n = OCS_TRIPPED;
                        run_n   = '0;
                    end else if (above_lvl1) begin
                        run_n = run_q + 1'b1;
                    end else begin
                        run_n = '0;
                    end
                end
            end
            OCS_TRIPPED: begin
                run_n = '0;
            end
            default: begin
                state_n = OCS_TRIPPED;
            end
        endcase
    end

    always_comb begin
        latched = (state_q == OCS_TRIPPED);
    end

endmodule

// File: rtl/bfm_ov_clamp.sv
module bfm_ov_clamp
    import bfm_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int OV_MV  = 1000,
    parameter int REL_MV = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vout,
    output logic              ls_on,
    output logic              latched
);
    localparam logic [CODE_W-1:0] OV_C  = CODE_W'(OV_MV);
    localparam logic [CODE_W-1:0] REL_C = CODE_W'(REL_MV);

    ov_state_t state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVS_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            OVS_IDLE:     if (vout > OV_C)  state_n = OVS_SINK;
            OVS_SINK:     if (vout < REL_C) state_n = OVS_RELEASED;
            OVS_RELEASED: if (vout > REL_C) state_n = OVS_SINK;
            default:      state_n = OVS_SINK;
        endcase
    end

    always_comb begin
        ls_on   = (state_q == OVS_SINK);
        latched = (state_q != OVS_IDLE);
    end

endmodule

// File: rtl/bfm_supervisor.sv
module bfm_supervisor
    import bfm_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int UV_MV    = 600,
    parameter int PG_LO_MV = 710,
    parameter int PG_HI_MV = 890
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_trip,
    input  logic              ss_done,
    input  logic              ov_latched,
    input  logic [CODE_W-1:0] vout,
    output logic              uv_latched,
    output logic              shut,
    output logic              pgood
);
    localparam logic [CODE_W-1:0] UV_C    = CODE_W'(UV_MV);
    localparam logic [CODE_W-1:0] PG_LO_C = CODE_W'(PG_LO_MV);
    localparam logic [CODE_W-1:0] PG_HI_C = CODE_W'(PG_HI_MV);

    sup_state_t state_q, state_n;
    logic       uv_q;
    logic       uv_trip, in_win, shut_req;

    assign uv_trip  = ss_done && (vout < UV_C);
    assign in_win   = (vout >= PG_LO_C) && (vout <= PG_HI_C);
    assign shut_req = oc_trip || uv_trip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SUP_SOFTSTART;
            uv_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            uv_q    <= uv_q | uv_trip;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SUP_SOFTSTART: begin
                if (shut_req)     state_n = SUP_SHUTDOWN;
                else if (ss_done) state_n = in_win ? SUP_GOOD : SUP_OUTSIDE;
            end
            SUP_GOOD: begin
                if (shut_req)     state_n = SUP_SHUTDOWN;
                else if (!in_win) state_n = SUP_OUTSIDE;
            end
            SUP_OUTSIDE: begin
                if (shut_req)     state_n = SUP_SHUTDOWN;
                else if (in_win)  state_n = SUP_GOOD;
            end
            SUP_SHUTDOWN: begin
                state_n = SUP_SHUTDOWN;
            end
            default: state_n = SUP_SHUTDOWN;
        endcase
    end

    always_comb begin
        uv_latched = uv_q;
        shut       = (state_q == SUP_SHUTDOWN);
        pgood      = (state_q == SUP_GOOD) && !ov_latched;
    end

endmodule

// File: rtl/buck_fault_mgr.sv
module buck_fault_mgr #(
    parameter int CODE_W    = 10,
    parameter int OC_RUN    = 4,
    parameter int UV_MV     = 600,
    parameter int OV_MV     = 1000,
    parameter int OV_REL_MV = 400,
    parameter int PG_LO_MV  = 710,
    parameter int PG_HI_MV  = 890
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_strobe,
    input  logic [CODE_W-1:0] ls_sample,
    input  logic [CODE_W-1:0] oc_thresh,
    input  logic [CODE_W-1:0] vout_sense,
    input  logic              ss_done,
    output logic              force_all_off,
    output logic              force_ls_on,
    output logic              fault_oc,
    output logic              fault_uv,
    output logic              fault_ov,
    output logic              pgood
);
    logic oc_trip, oc_latched;
    logic ov_ls_on, ov_latched;
    logic sup_shut, sup_uv, sup_pgood;

    bfm_oc_detect #(.CODE_W(CODE_W), .OC_RUN(OC_RUN)) u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (cyc_strobe),
        .sample  (ls_sample),
        .thr     (oc_thresh),
        .trip    (oc_trip),
        .latched (oc_latched)
    );

    bfm_ov_clamp #(.CODE_W(CODE_W), .OV_MV(OV_MV), .REL_MV(OV_REL_MV)) u_ov (
        .clk     (clk),
        .rst_n   (rst_n),
        .vout    (vout_sense),
        .ls_on   (ov_ls_on),
        .latched (ov_latched)
    );

    bfm_supervisor #(
        .CODE_W(CODE_W), .UV_MV(UV_MV), .PG_LO_MV(PG_LO_MV), .PG_HI_MV(PG_HI_MV)
    ) u_sup (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_trip    (oc_trip),
        .ss_done    (ss_done),
        .ov_latched (ov_latched),
        .vout       (vout_sense),
        .uv_latched (sup_uv),
        .shut       (sup_shut),
        .pgood      (sup_pgood)
    );

    // discharge path from the over-voltage clamp wins over shutdown
    always_comb begin
        force_ls_on   = ov_ls_on;
        force_all_off = (sup_shut || ov_latched) && !ov_ls_on;
        fault_oc      = oc_latched;
        fault_uv      = sup_uv;
        fault_ov      = ov_latched;
        pgood         = sup_pgood;
    end

endmodule

// File: rtl/buck_fault_mgr_chk.sv
module buck_fault_mgr_chk #(
    parameter int CODE_W    = 10,
    parameter int OV_MV     = 1000,
    parameter int OV_REL_MV = 400,
    parameter int PG_LO_MV  = 710,
    parameter int PG_HI_MV  = 890
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_strobe,
    input logic [CODE_W-1:0] ls_sample,
    input logic [CODE_W-1:0] oc_thresh,
    input logic [CODE_W-1:0] vout_sense,
    input logic              ss_done,
    input logic              force_all_off,
    input logic              force_ls_on,
    input logic              fault_oc,
    input logic              fault_uv,
    input logic              fault_ov,
    input logic              pgood
);
    localparam logic [CODE_W-1:0] OV_C  = CODE_W'(OV_MV);
    localparam logic [CODE_W-1:0] REL_C = CODE_W'(OV_REL_MV);
    localparam logic [CODE_W-1:0] LO_C  = CODE_W'(PG_LO_MV);
    localparam logic [CODE_W-1:0] HI_C  = CODE_W'(PG_HI_MV);

    logic [CODE_W:0] lvl2;
    assign lvl2 = {1'b0, oc_thresh} + {2'b00, oc_thresh[CODE_W-1:1]};

    assert_instant_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && ({1'b0, ls_sample} > lvl2)) |=> fault_oc);

    assert_oc_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_oc |=> fault_oc);

    assert_uv_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_uv |=> fault_uv);

    assert_fault_overrides_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_oc || fault_uv) |-> (force_all_off || force_ls_on));

    assert_uv_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_done && !fault_uv) |=> !fault_uv);

    assert_ov_sink_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vout_sense > OV_C) |=> (fault_ov && force_ls_on));

    assert_ov_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ov && vout_sense < REL_C) |=> (!force_ls_on && force_all_off));

    assert_ov_redrive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ov && vout_sense > REL_C) |=> force_ls_on);

    assert_window_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((vout_sense < LO_C) || (vout_sense > HI_C)) |=> !pgood);

    assert_fault_masks_pg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_oc || fault_uv || fault_ov) |-> !pgood);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_all_off && force_ls_on));

endmodule

bind buck_fault_mgr buck_fault_mgr_chk u_chk (.*);

// File: tb/buck_fault_mgr_bench.sv
module buck_fault_mgr_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_strobe = 1'b0;
    logic [9:0] ls_sample = '0;
    logic [9:0] oc_thresh = '0;
    logic [9:0] vout_sense = '0;
    logic       ss_done = 1'b0;
    logic       force_all_off, force_ls_on, fault_oc, fault_uv, fault_ov, pgood;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // expectation model state, built from the requirements
    int m_run, m_sup, m_ov;
    bit m_oc, m_uv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    buck_fault_mgr u_buck_fault_mgr (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ls_sample(ls_sample),
        .oc_thresh(oc_thresh), .vout_sense(vout_sense), .ss_done(ss_done),
        .force_all_off(force_all_off), .force_ls_on(force_ls_on),
        .fault_oc(fault_oc), .fault_uv(fault_uv), .fault_ov(fault_ov), .pgood(pgood)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_ls_on();
        return m_ov == 1;
    endfunction

    function automatic bit exp_all_off();
        return (m_sup == 3 || m_ov == 2) && m_ov != 1;
    endfunction

    function automatic bit exp_pg();
        return m_sup == 1 && m_ov == 0;
    endfunction

    task automatic model_update(input bit stb, input int sw, input int thr,
                                input int vo, input bit ssd);
        bit l1, l2, trip, uvt, win, sreq;
        l1   = sw > thr;
        l2   = sw > thr + (thr >> 1);
        trip = stb && !m_oc && (l2 || (l1 && m_run == 3));
        if (stb && !m_oc) m_run = trip ? 0 : (l1 ? m_run + 1 : 0);
        uvt  = ssd && vo < 600;
        win  = vo >= 710 && vo <= 890;
        sreq = trip || uvt;
        case (m_sup)
            0: if (sreq) m_sup = 3; else if (ssd) m_sup = win ? 1 : 2;
            1, 2: if (sreq) m_sup = 3; else m_sup = win ? 1 : 2;
            default: m_sup = 3;
        endcase
        if (trip) m_oc = 1;
        if (uvt) m_uv = 1;
        case (m_ov)
            0: if (vo > 1000) m_ov = 1;
            1: if (vo < 400) m_ov = 2;
            default: if (vo > 400) m_ov = 1;
        endcase
    endtask

    task automatic compare_all();
        check("R1 fault_oc", int'(fault_oc), int'(m_oc));
        check("R4 fault_uv", int'(fault_uv), int'(m_uv));
        check("R5 fault_ov", int'(fault_ov), int'(m_ov != 0));
        check("R6 force_ls_on", int'(force_ls_on), int'(exp_ls_on()));
        check("R3 force_all_off", int'(force_all_off), int'(exp_all_off()));
        check("R7 pgood", int'(pgood), int'(exp_pg()));
    endtask

    // one cycle: drive at falling edge, result due after the next rising edge (R11)
    task automatic step(input bit stb, input int sw, input int vo, input bit ssd);
        cyc_strobe = stb;
        ls_sample  = 10'(sw);
        vout_sense = 10'(vo);
        ss_done    = ssd;
        model_update(stb, sw, int'(oc_thresh), vo, ssd);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input int thr);
        rst_n      = 1'b0;
        cyc_strobe = 1'b0;
        ss_done    = 1'b0;
        vout_sense = 10'd800;
        ls_sample  = '0;
        oc_thresh  = 10'(thr);
        m_run = 0; m_sup = 0; m_ov = 0; m_oc = 0; m_uv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R3 reset all_off", int'(force_all_off), 0);
        check("R3 reset ls_on", int'(force_ls_on), 0);
        check("R3 reset faults", int'({fault_oc, fault_uv, fault_ov}), 0);
        check("R3 reset pgood", int'(pgood), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);

        // R1 R10: run kept over strobe-free cycles, during soft-start
        do_reset(100);
        repeat (3) step(1, 120, 800, 0);
        repeat (2) step(0, 120, 800, 0);
        check("R1 run of 3 no trip", int'(fault_oc), 0);
        step(1, 120, 800, 0);
        check("R10 fourth event trips in soft-start", int'(fault_oc), 1);
        check("R3 oc forces off", int'(force_all_off), 1);

        // R1: a clean strobe breaks the run
        do_reset(100);
        repeat (3) step(1, 120, 800, 0);
        step(1, 90, 800, 0);
        repeat (3) step(1, 120, 800, 0);
        check("R1 broken run no trip", int'(fault_oc), 0);
        step(1, 120, 800, 0);
        check("R1 new run of 4 trips", int'(fault_oc), 1);

        // R2: boundary 150 / 151 at threshold 100
        do_reset(100);
        step(1, 150, 800, 0);
        check("R2 equal to 1.5x no trip", int'(fault_oc), 0);
        step(1, 90, 800, 0);
        step(1, 151, 800, 0);
        check("R2 above 1.5x trips", int'(fault_oc), 1);

        // R2: 700 * 1.5 = 1050 must not wrap
        do_reset(700);
        step(1, 1023, 800, 0);
        check("R2 no wrap of 1.5x", int'(fault_oc), 0);

        // R4: masked before soft-start done
        do_reset(100);
        repeat (4) step(0, 0, 300, 0);
        check("R4 uv masked", int'(fault_uv), 0);
        check("R4 uv masked no override", int'(force_all_off), 0);
        step(0, 0, 300, 1);
        check("R4 uv latches", int'(fault_uv), 1);
        check("R3 uv forces off", int'(force_all_off), 1);
        step(0, 0, 800, 1);
        check("R8 pgood low after uv", int'(pgood), 0);

        // R5 R6 R10 R8: clamp hysteresis
        do_reset(100);
        step(0, 0, 1000, 0);
        check("R5 1000 no ov", int'(fault_ov), 0);
        step(0, 0, 1001, 0);
        check("R5 ov latches", int'(fault_ov), 1);
        check("R10 ls on in soft-start", int'(force_ls_on), 1);
        step(0, 0, 400, 0);
        check("R6 400 holds on", int'(force_ls_on), 1);
        step(0, 0, 399, 0);
        check("R6 below 400 release", int'(force_ls_on), 0);
        check("R6 released both off", int'(force_all_off), 1);
        step(0, 0, 400, 0);
        check("R6 400 holds off", int'(force_ls_on), 0);
        step(0, 0, 401, 0);
        check("R6 above 400 redrive", int'(force_ls_on), 1);
        step(0, 0, 800, 1);
        check("R8 pgood masked by ov", int'(pgood), 0);

        // R7: window edges
        do_reset(100);
        step(0, 0, 800, 0);
        check("R7 pgood low in soft-start", int'(pgood), 0);
        step(0, 0, 800, 1);
        check("R7 pgood after soft-start", int'(pgood), 1);
        step(0, 0, 890, 1);
        check("R7 890 inside", int'(pgood), 1);
        step(0, 0, 891, 1);
        check("R7 891 outside", int'(pgood), 0);
        check("R7 switching continues", int'(force_all_off | force_ls_on), 0);
        step(0, 0, 710, 1);
        check("R8 re-entry at 710", int'(pgood), 1);
        step(0, 0, 709, 1);
        check("R7 709 outside", int'(pgood), 0);

        // R9: over-voltage and over-current together
        do_reset(100);
        step(1, 200, 1001, 0);
        check("R9 ls_on wins", int'(force_ls_on), 1);
        check("R9 all_off yields", int'(force_all_off), 0);
        check("R9 oc still latched", int'(fault_oc), 1);
        step(0, 0, 300, 0);
        check("R9 released then off", int'(force_all_off), 1);

        // constrained random runs
        for (int run = 0; run < 40; run++) begin
            int thr, ssd_at;
            thr    = 50 + int'($urandom % 550);
            ssd_at = int'($urandom % 20);
            do_reset(thr);
            for (int c = 0; c < 60; c++) begin
                int sw, vo, r;
                bit stb;
                stb = bit'($urandom % 2);
                r = int'($urandom % 10);
                if (r < 6)      sw = thr - int'($urandom % 50);
                else if (r < 9) sw = thr + 1 + int'($urandom % (thr / 2 + 1));
                else            sw = thr + thr / 2 + 1 + int'($urandom % 20);
                if (sw < 0) sw = 0;
                if (sw > 1023) sw = 1023;
                r = int'($urandom % 20);
                if (r < 14)      vo = 700 + int'($urandom % 200);
                else if (r < 16) vo = 550 + int'($urandom % 200);
                else if (r < 18) vo = 380 + int'($urandom % 40);
                else             vo = 990 + int'($urandom % 30);
                step(stb, sw, vo, c >= ssd_at);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule